// File: doc/BRIEF.md
# Command-Sequenced I2C Byte Master

This block is an I2C master that a processor drives one bus primitive at a time. Each write of a 4-bit command code starts one action: a START condition, a STOP condition, a byte transmit, a byte receive that ends with the master driving ACK, or a final-byte receive that ends with the master leaving SDA high. A data register holds the byte to send and collects the byte received. Status outputs report busy, a one-cycle done pulse for use as an interrupt, a sticky error flag and the acknowledge bit returned by the target.

SCL comes from a divided system clock. One bit slot lasts four quarter periods of `QTR_CYCLES` system clocks each. SCL is low for the first two quarters and high for the last two. After the first bus command, SCL keeps toggling between commands, with SDA held still. It stops, parked high, only when the no-op command is issued. SDA is open-drain. `sda_oe_o` high pulls the line low, and `sda_i` returns the wired level of the line.

Every action begins at a slot boundary, which is the falling edge of SCL. A command written while the clock is stopped starts at the next quarter tick.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset, busy_o, done_o, err_o and nack_o are 0, data_o is 0x00, scl_o is 1 and sda_oe_o is 0.
- R2: Command 4'b1001 makes a START: SDA goes from released to driven low while SCL is high, and SCL then keeps toggling.
- R3: Command 4'b0101 makes a STOP: SDA goes from driven low to released while SCL is high.
- R4: Command 4'b0011 sends data_o on SDA MSB first over eight SCL pulses. SDA is released in the ninth pulse, and the line level sampled there is stored in nack_o (1 = NACK, 0 = ACK).
- R5: Command 4'b0010 reads eight bits MSB first into data_o and drives SDA low (ACK) during the ninth SCL pulse.
- R6: Command 4'b0110 reads eight bits MSB first into data_o and keeps SDA released (NACK) during the ninth SCL pulse.
- R7: While running, SCL has a period of 4*QTR_CYCLES system clocks, even between commands. Command 4'b0000 stops it at the next slot boundary, after which scl_o stays 1.
- R8: Any other command code leaves the bus untouched, does not raise busy_o, and sets err_o on the next cycle.
- R9: err_o stays set until err_clr_i is driven high for a cycle. A new invalid command in that same cycle wins.
- R10: busy_o rises the cycle after a valid command is accepted and falls when the action completes. done_o is high for exactly that one cycle.
- R11: Commands and data writes presented while busy_o is high are dropped: no bus action, no error, and data_o is unchanged.
- R12: While SCL stays high, sda_oe_o changes only as part of a START or a STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 4 | Command code |
| data_we_i | input | 1 | Data register write strobe |
| data_i | input | 8 | Byte to load into the data register |
| err_clr_i | input | 1 | Write-one-to-clear for the error flag |
| sda_i | input | 1 | Level seen on the SDA line |
| scl_o | output | 1 | Serial clock |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| data_o | output | 8 | Data register contents |
| busy_o | output | 1 | An accepted command is pending or running |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Sticky invalid-command flag |
| nack_o | output | 1 | Acknowledge bit from the last transmit, 1 = NACK |

## Verification
The properties assume that `sda_i` is the wired-AND of the master's own drive and a target that changes the line only while SCL is low. They also assume that nothing holds SCL low, since clock stretching is not modelled. The bench meets these conditions with a target model that updates SDA only just after an SCL fall. That model counts slots from the first fall after each accepted transfer command and checks every START, STOP and byte against a scoreboard queue. Commands are written away from the clock edge and held for one cycle. The ignored-while-busy cases are sent deliberately in the middle of a transfer.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    localparam logic [3:0] CODE_NOOP   = 4'b0000;
    localparam logic [3:0] CODE_RXACK  = 4'b0010;
    localparam logic [3:0] CODE_TX     = 4'b0011;
    localparam logic [3:0] CODE_STOP   = 4'b0101;
    localparam logic [3:0] CODE_RXLAST = 4'b0110;
    localparam logic [3:0] CODE_START  = 4'b1001;

    localparam int          BYTE_BITS = 8;
    localparam int          SLOT_W    = $clog2(BYTE_BITS + 1);
    localparam logic [SLOT_W-1:0] ACK_SLOT = SLOT_W'(BYTE_BITS);

    typedef enum logic [2:0] {
        OP_NOOP,
        OP_START,
        OP_STOP,
        OP_TX,
        OP_RXACK,
        OP_RXLAST,
        OP_BAD
    } op_e;

    typedef struct packed {
        logic                 busy;
        logic                 exec;
        logic                 run;
        logic [1:0]           phase;
        op_e                  op;
        logic [SLOT_W-1:0]    slot;
        logic [BYTE_BITS-1:0] sh;
        logic [BYTE_BITS-1:0] data;
        logic                 sda_oe;
        logic                 nack;
        logic                 err;
        logic                 done;
    } mst_state_t;

    localparam mst_state_t MST_RESET = '{
        busy:   1'b0,
        exec:   1'b0,
        run:    1'b0,
        phase:  2'd3,
        op:     OP_NOOP,
        slot:   '0,
        sh:     '0,
        data:   '0,
        sda_oe: 1'b0,
        nack:   1'b0,
        err:    1'b0,
        done:   1'b0
    };

endpackage

// File: rtl/i2c_quarter_tick.sv
module i2c_quarter_tick #(
    parameter int QTR_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    output logic tick_o
);
    localparam int CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = (cnt_q == LAST);
        cnt_d  = tick_o ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end
endmodule

// File: rtl/i2c_cmd_decode.sv
module i2c_cmd_decode
    import i2c_cmd_pkg::*;
(
    input  logic [3:0] cmd_i,
    output op_e        op_o
);
    always_comb begin
        case (cmd_i)
            CODE_NOOP:   op_o = OP_NOOP;
            CODE_START:  op_o = OP_START;
            CODE_STOP:   op_o = OP_STOP;
            CODE_TX:     op_o = OP_TX;
            CODE_RXACK:  op_o = OP_RXACK;
            CODE_RXLAST: op_o = OP_RXLAST;
            default:     op_o = OP_BAD;
        endcase
    end
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master
    import i2c_cmd_pkg::*;
#(
    parameter int QTR_CYCLES = 4
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       cmd_we_i,
    input  logic [3:0] cmd_i,
    input  logic       data_we_i,
    input  logic [7:0] data_i,
    input  logic       err_clr_i,
    input  logic       sda_i,
    output logic       scl_o,
    output logic       sda_oe_o,
    output logic [7:0] data_o,
    output logic       busy_o,
    output logic       done_o,
    output logic       err_o,
    output logic       nack_o
);
    logic       tick;
    op_e        dec_op;
    logic       accept;
    logic       is_xfer;
    logic       is_rx;
    mst_state_t st_d, st_q;

    i2c_quarter_tick #(.QTR_CYCLES(QTR_CYCLES)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_o (tick)
    );

    i2c_cmd_decode u_dec (
        .cmd_i (cmd_i),
        .op_o  (dec_op)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = cmd_we_i && !st_q.busy;
        is_rx     = (st_q.op == OP_RXACK) || (st_q.op == OP_RXLAST);
        is_xfer   = is_rx || (st_q.op == OP_TX);

        // register side: data load, error clear, command accept
        if (data_we_i && !st_q.busy) st_d.data = data_i;
        if (err_clr_i) st_d.err = 1'b0;
        if (accept) begin
            if (dec_op == OP_BAD) begin
                st_d.err = 1'b1;
            end else begin
                st_d.busy = 1'b1;
                st_d.exec = 1'b0;
                st_d.op   = dec_op;
            end
        end

        // bus side: quarter-period sequencing
        if (tick) begin
            case (st_q.phase)
                2'd0, 2'd1: st_d.phase = st_q.phase + 2'd1;
                2'd2: begin
                    // entering the middle of SCL high
                    st_d.phase = 2'd3;
                    if (st_q.exec) begin
                        case (st_q.op)
                            OP_START: st_d.sda_oe = 1'b1;
                            OP_STOP:  st_d.sda_oe = 1'b0;
                            OP_TX: begin
                                if (st_q.slot == ACK_SLOT) st_d.nack = sda_i;
                            end
                            OP_RXACK, OP_RXLAST: begin
                                if (st_q.slot != ACK_SLOT)
                                    st_d.sh = {st_q.sh[BYTE_BITS-2:0], sda_i};
                            end
                            default: ;
                        endcase
                    end
                end
                default: begin
                    // slot boundary: SCL falls if the clock runs
                    st_d.phase = st_q.run ? 2'd0 : 2'd3;
                    if (st_q.busy && !st_q.exec) begin
                        if (st_q.op == OP_NOOP) begin
                            st_d.run   = 1'b0;
                            st_d.busy  = 1'b0;
                            st_d.done  = 1'b1;
                            st_d.phase = 2'd3;
                        end else begin
                            st_d.exec  = 1'b1;
                            st_d.run   = 1'b1;
                            st_d.phase = 2'd0;
                            st_d.slot  = '0;
                            case (st_q.op)
                                OP_START: st_d.sda_oe = 1'b0;
                                OP_STOP:  st_d.sda_oe = 1'b1;
                                OP_TX: begin
                                    st_d.sda_oe = ~st_q.data[BYTE_BITS-1];
                                    st_d.sh     = {st_q.data[BYTE_BITS-2:0], 1'b0};
                                end
                                default:  st_d.sda_oe = 1'b0;
                            endcase
                        end
                    end else if (st_q.exec) begin
                        if (!is_xfer || (st_q.slot == ACK_SLOT)) begin
                            st_d.exec = 1'b0;
                            st_d.busy = 1'b0;
                            st_d.done = 1'b1;
                            if (is_xfer) st_d.sda_oe = 1'b0;
                            if (is_rx)   st_d.data   = st_q.sh;
                        end else begin
                            st_d.slot = st_q.slot + 1'b1;
                            if (st_q.slot + 1'b1 == ACK_SLOT) begin
                                st_d.sda_oe = (st_q.op == OP_RXACK);
                            end else if (st_q.op == OP_TX) begin
                                st_d.sda_oe = ~st_q.sh[BYTE_BITS-1];
                                st_d.sh     = {st_q.sh[BYTE_BITS-2:0], 1'b0};
                            end else begin
                                st_d.sda_oe = 1'b0;
                            end
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= MST_RESET;
        else         st_q <= st_d;
    end

    assign scl_o    = st_q.phase[1];
    assign sda_oe_o = st_q.sda_oe;
    assign data_o   = st_q.data;
    assign busy_o   = st_q.busy;
    assign done_o   = st_q.done;
    assign err_o    = st_q.err;
    assign nack_o   = st_q.nack;
endmodule

// File: rtl/i2c_cmd_master_chk.sv
module i2c_cmd_master_chk
    import i2c_cmd_pkg::*;
(
    input logic       clk_i,
    input logic       rst_ni,
    input logic       cmd_we_i,
    input logic [3:0] cmd_i,
    input logic       err_clr_i,
    input logic       scl_o,
    input logic       sda_oe_o,
    input logic       busy_o,
    input logic       done_o,
    input logic       err_o,
    input op_e        cur_op
);
    logic bad_code;
    assign bad_code = !(cmd_i inside {CODE_NOOP, CODE_RXACK, CODE_TX,
                                      CODE_STOP, CODE_RXLAST, CODE_START});

    AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o); // R10

    AST_BUSY_FALL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> done_o); // R10

    AST_GOOD_RAISES_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && !busy_o && !bad_code) |=> busy_o); // R10

    AST_BAD_SETS_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && !busy_o && bad_code) |=> (err_o && !busy_o)); // R8

    AST_CLEAR_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_clr_i && !(cmd_we_i && !busy_o && bad_code)) |=> !err_o); // R9

    AST_BUSY_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !err_o) |=> !err_o); // R11

    AST_SDA_HIGH_ONLY_COND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (scl_o && $past(scl_o) && (sda_oe_o != $past(sda_oe_o)))
            |-> (cur_op == OP_START || cur_op == OP_STOP)); // R12
endmodule

bind i2c_cmd_master i2c_cmd_master_chk u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cmd_we_i  (cmd_we_i),
    .cmd_i     (cmd_i),
    .err_clr_i (err_clr_i),
    .scl_o     (scl_o),
    .sda_oe_o  (sda_oe_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .err_o     (err_o),
    .cur_op    (st_q.op)
);

// File: tb/tb_i2c_cmd_master.sv
module tb_i2c_cmd_master;
    localparam int QTR = 4;
    localparam int PERIOD_CYC = 4 * QTR;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [3:0] cmd = 4'h0;
    logic       data_we = 1'b0;
    logic [7:0] data_in = 8'h00;
    logic       err_clr = 1'b0;
    logic       scl, sda_oe, busy, done, err, nack;
    logic [7:0] data_out;
    logic       tgt_low = 1'b0;
    logic       sda_line;

    assign sda_line = ~(sda_oe | tgt_low);

    always #2 clk = ~clk;

    i2c_cmd_master #(.QTR_CYCLES(QTR)) dut (
        .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_i(cmd),
        .data_we_i(data_we), .data_i(data_in), .err_clr_i(err_clr),
        .sda_i(sda_line), .scl_o(scl), .sda_oe_o(sda_oe), .data_o(data_out),
        .busy_o(busy), .done_o(done), .err_o(err), .nack_o(nack)
    );

    // scoreboard
    typedef struct {
        int         kind;   // 0 START, 1 STOP, 2 byte
        logic [7:0] b;
        logic       ack;
        string      req;
    } exp_t;
    exp_t exp_q[$];

    int n_chk = 0, n_err = 0, m_chk = 0, m_err = 0;
    int rise_cnt = 0;
    logic [7:0] tgt_byte = 8'h00;
    logic       tgt_nack = 1'b0;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    task automatic push_exp(input int kind, input logic [7:0] b, input logic ack, input string req);
        exp_t e;
        e.kind = kind; e.b = b; e.ack = ack; e.req = req;
        exp_q.push_back(e);
    endtask

    // monitor and target model, sampled away from the active edge
    logic scl_p = 1'b1, sda_p = 1'b1;
    int   slot = 0;
    bit   armed = 0, arm_next = 0;
    int   mode = 0, mode_next = 0;   // 1 tx, 2 rx ack, 3 rx last
    logic [7:0] obs_b = 8'h00;

    task automatic observe(input int kind, input logic [7:0] b, input logic ack);
        exp_t e;
        m_chk++;
        if (exp_q.size() == 0) begin
            m_err++;
            $display("FAIL R11: actual=unexpected bus event kind %0d expected=none", kind);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || (kind == 2 && (e.b !== b || e.ack !== ack))) begin
                m_err++;
                $display("FAIL %s: actual=kind %0d byte %0h ack %0b expected=kind %0d byte %0h ack %0b",
                         e.req, kind, b, ack, e.kind, e.b, e.ack);
            end
        end
    endtask

    always @(negedge clk) begin
        logic scl_n, sda_n;
        if (!rst_n) begin
            scl_p = 1'b1; sda_p = 1'b1; armed = 0; arm_next = 0; tgt_low = 1'b0;
        end else begin
            scl_n = scl;
            sda_n = sda_line;
            if (scl_p && scl_n && (sda_p !== sda_n))
                observe(sda_n ? 1 : 0, 8'h00, 1'b0);
            if (!scl_p && scl_n) rise_cnt++;
            if (armed && scl_p && !scl_n) begin
                slot++;
                if (slot < 8)       tgt_low = (mode >= 2) ? ~tgt_byte[7-slot] : 1'b0;
                else if (slot == 8) tgt_low = (mode == 1) ? ~tgt_nack : 1'b0;
                else begin
                    tgt_low = 1'b0;
                    armed   = 0;
                end
            end
            if (armed && !scl_p && scl_n && slot >= 0 && slot <= 8) begin
                if (slot < 8) obs_b = {obs_b[6:0], sda_n};
                else          observe(2, obs_b, sda_n);
            end
            if (arm_next) begin
                armed = 1; slot = -1; mode = mode_next; arm_next = 0;
            end
            if (cmd_we && !busy && (cmd == 4'b0011 || cmd == 4'b0010 || cmd == 4'b0110)) begin
                arm_next  = 1;
                mode_next = (cmd == 4'b0011) ? 1 : (cmd == 4'b0010) ? 2 : 3;
            end
            sda_p = sda_n;
            scl_p = scl_n;
        end
    end

    task automatic issue(input logic [3:0] code);
        @(posedge clk); #1;
        cmd_we = 1'b1; cmd = code;
        @(posedge clk); #1;
        cmd_we = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err + m_err, n_chk + m_chk);
        $finish;
    endtask

    initial begin : watchdog
        #(200000 * 4);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual=hung expected=finished");
        finish_run();
    end

    initial begin : main
        int r0;
        repeat (5) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 err", err, 0);
        check("R1 done", done, 0);
        check("R1 nack", nack, 0);
        check("R1 scl", scl, 1);
        check("R1 sda_oe", sda_oe, 0);
        check("R1 data", data_out, 8'h00);
        #1 rst_n = 1'b1;

        // R2 start from a stopped clock
        push_exp(0, 8'h00, 1'b0, "R2");
        issue(4'b1001);
        check("R10 busy after accept", busy, 1);
        wait_done();
        check("R10 done with busy low", busy, 0);
        @(negedge clk);
        check("R10 done single cycle", done, 0);

        // R4 transmit with ACK
        @(posedge clk); #1 data_we = 1'b1; data_in = 8'hA5;
        @(posedge clk); #1 data_we = 1'b0;
        tgt_nack = 1'b0;
        push_exp(2, 8'hA5, 1'b0, "R4");
        issue(4'b0011);
        wait_done();
        check("R4 ack stored", nack, 0);

        // R4 transmit with NACK
        @(posedge clk); #1 data_we = 1'b1; data_in = 8'h3C;
        @(posedge clk); #1 data_we = 1'b0;
        tgt_nack = 1'b1;
        push_exp(2, 8'h3C, 1'b1, "R4");
        issue(4'b0011);
        wait_done();
        check("R4 nack stored", nack, 1);

        // R5 receive with ACK; R11 command and data write during busy
        tgt_byte = 8'h96;
        push_exp(2, 8'h96, 1'b0, "R5");
        issue(4'b0010);
        repeat (20) @(posedge clk);
        #1 data_we = 1'b1; data_in = 8'h00;
        @(posedge clk); #1 data_we = 1'b0;
        issue(4'b1001);
        check("R11 no error while busy", err, 0);
        wait_done();
        check("R5 received byte", data_out, 8'h96);
        check("R11 data write dropped", data_out, 8'h96);

        // R6 final receive without ACK
        tgt_byte = 8'h5B;
        push_exp(2, 8'h5B, 1'b1, "R6");
        issue(4'b0110);
        wait_done();
        check("R6 received byte", data_out, 8'h5B);

        // R3 stop
        push_exp(1, 8'h00, 1'b0, "R3");
        issue(4'b0101);
        wait_done();

        // R7 clock keeps running between commands
        r0 = rise_cnt;
        repeat (4 * PERIOD_CYC) @(negedge clk);
        check("R7 idle toggling", rise_cnt - r0, 4);

        // R7 no-op stops the clock
        issue(4'b0000);
        wait_done();
        r0 = rise_cnt;
        repeat (4 * PERIOD_CYC) @(negedge clk);
        check("R7 stopped no rises", rise_cnt - r0, 0);
        check("R7 parked high", scl, 1);

        // R8 invalid codes
        issue(4'b0111);
        check("R8 err set", err, 1);
        check("R8 no busy", busy, 0);
        r0 = rise_cnt;
        repeat (2 * PERIOD_CYC) @(negedge clk);
        check("R8 bus untouched", rise_cnt - r0, 0);
        issue(4'b1111);
        check("R8 err still set", err, 1);

        // R9 clear
        @(posedge clk); #1 err_clr = 1'b1;
        @(posedge clk); #1 err_clr = 1'b0;
        check("R9 err cleared", err, 0);

        // R2 restart, transmit, stop
        push_exp(0, 8'h00, 1'b0, "R2");
        issue(4'b1001);
        wait_done();
        @(posedge clk); #1 data_we = 1'b1; data_in = 8'h01;
        @(posedge clk); #1 data_we = 1'b0;
        tgt_nack = 1'b0;
        push_exp(2, 8'h01, 1'b0, "R4");
        issue(4'b0011);
        wait_done();
        check("R4 ack after restart", nack, 0);
        push_exp(1, 8'h00, 1'b0, "R3");
        issue(4'b0101);
        wait_done();
        r0 = rise_cnt;
        repeat (2 * PERIOD_CYC) @(negedge clk);
        check("R2 clock running after start", rise_cnt - r0, 2);

        check("R11 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule